// File: doc/BRIEF.md
# UART Receive Descriptor-Ring Engine

This block sits behind a UART character receiver and moves each received byte into a memory buffer. Buffers are described by a ring of descriptors kept in an internal table. Each descriptor has four 16-bit words: a status/control word, a received-length word, and a 32-bit buffer pointer (upper half, then lower half). The engine may fill a descriptor only while that descriptor's empty flag is set. A buffer is closed when one of three things happens: the buffer reaches the configured maximum length, a reception error is reported, or a configured number of idle characters arrive in a row. On close the engine writes the length word, then writes the status word last. It then raises a receive event if the descriptor asks for one, and steps to the next descriptor.

Characters enter on a valid/ready stream. A character is taken on a clock edge where `ch_valid` and `ch_ready` are both high, and the sender holds it until then. The engine lowers `ch_ready` while a byte is waiting on the memory port and during the two cycles of a close. This back-pressure is the only way it slows the receiver. Bytes leave on a valid/ready memory write port. `mw_valid` stays asserted, with address and data unchanged, until `mw_ready` is seen high. The host reads and writes the table through a plain word port. If the host and the engine write the same word in the same cycle, the engine's write wins. The status word uses MSB-first numbering: status bit n is vector bit 15-n.

Top module: `rxq_bd_engine`

## Requirements
- R1: A character that arrives while the current descriptor has E (status bit 0, vector bit 15) clear is consumed and dropped. It causes no memory write, and it sets the sticky `ev_busy` flag.
- R2: Each data character (ch_idle=0, ch_err=0) is written to buffer pointer plus the byte offset within the buffer, in arrival order. An offered write holds `mw_addr` and `mw_data` stable until `mw_ready`.
- R3: When the byte count reaches `cfg_max_len`, the buffer closes. The length word (word 1) receives the count, and then the status word is written with E cleared (CM=0), ID clear and all error flags clear.
- R4: When `cfg_idle_lim` consecutive idle characters (ch_idle=1) arrive after at least one byte, the buffer closes with ID (status bit 7, vector bit 8) set. Any data character resets the idle run.
- R5: Idle characters received while the current buffer holds zero bytes neither close it nor change it.
- R6: A character with any error bit set closes the buffer, and that character is not stored. ch_err[3:0] = {break, framing, parity, overrun} map to status bits 10, 11, 12, 14 (vector bits 5, 4, 3, 1). E is cleared even when CM=1.
- R7: When CM (status bit 6, vector bit 9) is set and the close was not caused by an error, E stays set. The next visit to that descriptor overwrites its buffer from offset 0.
- R8: After a close, the next descriptor is entry 0 if W (status bit 2, vector bit 13) was set. Otherwise it is the following entry, and the last entry is followed by entry 0.
- R9: A close of a descriptor with I (status bit 3, vector bit 12) set sets the sticky `ev_rx` flag. `irq` = (ev_rx & cfg_irq_mask[0]) | (ev_busy & cfg_irq_mask[1]). Writing 1 to `ev_clr[0]` clears `ev_rx`, and writing 1 to `ev_clr[1]` clears `ev_busy`.
- R10: The written status keeps W, I and CM. It clears the reserved bits (status bits 1, 4, 5, 8, 9, 13, 15) and any error flags not seen in this buffer.
- R11: `ch_ready` is low while a byte write is pending on the memory port and during a close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | Character offered |
| ch_ready | output | 1 | Engine can take a character |
| ch_data | input | 8 | Received byte |
| ch_idle | input | 1 | Character is an idle character |
| ch_err | input | 4 | {break, framing, parity, overrun} |
| cfg_max_len | input | 16 | Buffer size in bytes |
| cfg_idle_lim | input | 16 | Idle run that closes a buffer (0 disables) |
| cfg_irq_mask | input | 2 | Enables: [0] receive, [1] busy |
| ev_clr | input | 2 | Write-one clear: [0] receive, [1] busy |
| mw_valid | output | 1 | Memory byte write offered |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | 32 | Byte address |
| mw_data | output | 8 | Byte value |
| host_we | input | 1 | Host table write strobe |
| host_addr | input | 5 | {descriptor index, word index} |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Table word at host_addr |
| ev_rx | output | 1 | Sticky receive event |
| ev_busy | output | 1 | Sticky busy event |
| irq | output | 1 | Masked interrupt request |

## Verification
The in-RTL assertions check the following on every cycle:
- memory-port hold rules and that an accepted data byte is offered on the next cycle;
- that a dropped character never reaches memory and always raises the busy flag;
- the length-then-status order of a close;
- that reserved status bits are written as zero;
- that the event flags are sticky;
- that the stream is refused while the engine is busy.

Only the bench scenarios can show which close condition fires and when. These include the idle run being reset by data, idle characters ignored in an empty buffer, and error flags landing in the right bit positions. They also cover the path through the ring under wrap and continuous-mode ownership, and the buffer overwrite on a revisit.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 2 * WORD_W;

  // Vector positions of status fields (MSB-first field n sits at 15-n)
  localparam int S_EMPTY = 15;
  localparam int S_WRAP  = 13;
  localparam int S_INTR  = 12;
  localparam int S_CONT  = 9;
  localparam int S_IDLE  = 8;
  localparam int S_BRK   = 5;
  localparam int S_FRM   = 4;
  localparam int S_PAR   = 3;
  localparam int S_OVR   = 1;

  localparam logic [WORD_W-1:0] CTL_KEEP  = 16'h3200; // wrap, interrupt, continuous
  localparam logic [WORD_W-1:0] RESV_MASK = 16'h4CC5;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_MEM  = 2'd1,
    ST_LEN  = 2'd2,
    ST_STAT = 2'd3
  } eng_state_e;
endpackage

// File: rtl/rxbd_table.sv
module rxbd_table
  import rxbd_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int IDX_W  = $clog2(N_DESC),
  parameter int HA_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [WORD_W-1:0] cur_stat,
  output logic [PTR_W-1:0]  cur_ptr,
  input  logic              eng_len_we,
  input  logic [WORD_W-1:0] eng_len,
  input  logic              eng_stat_we,
  input  logic [WORD_W-1:0] eng_stat
);
  localparam int DEPTH = N_DESC * 4;

  logic [WORD_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else begin
      if (host_we)     words[host_addr]       <= host_wdata;
      // engine writes come later so they take precedence
      if (eng_len_we)  words[{cur_idx, 2'd1}] <= eng_len;
      if (eng_stat_we) words[{cur_idx, 2'd0}] <= eng_stat;
    end
  end

  assign host_rdata = words[host_addr];
  assign cur_stat   = words[{cur_idx, 2'd0}];
  assign cur_ptr    = {words[{cur_idx, 2'd2}], words[{cur_idx, 2'd3}]};

  p_resv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stat_we |-> ((eng_stat & RESV_MASK) == '0));
endmodule

// File: rtl/rxbd_events.sv
module rxbd_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_rx,
  input  logic       set_busy,
  input  logic [1:0] clr,
  input  logic [1:0] mask,
  output logic       ev_rx,
  output logic       ev_busy,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_rx   <= 1'b0;
      ev_busy <= 1'b0;
    end else begin
      ev_rx   <= set_rx   | (ev_rx   & ~clr[0]);
      ev_busy <= set_busy | (ev_busy & ~clr[1]);
    end
  end

  assign irq = (ev_rx & mask[0]) | (ev_busy & mask[1]);

  p_rx_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && !clr[0]) |=> ev_rx);
  p_busy_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_busy && !clr[1]) |=> ev_busy);
endmodule

// File: rtl/rxq_bd_engine.sv
module rxq_bd_engine
  import rxbd_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  parameter int IDX_W  = $clog2(N_DESC),
  parameter int HA_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_valid,
  output logic              ch_ready,
  input  logic [DATA_W-1:0] ch_data,
  input  logic              ch_idle,
  input  logic [ERR_W-1:0]  ch_err,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic [LEN_W-1:0]  cfg_idle_lim,
  input  logic [1:0]        cfg_irq_mask,
  input  logic [1:0]        ev_clr,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [PTR_W-1:0]  mw_addr,
  output logic [DATA_W-1:0] mw_data,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              ev_rx,
  output logic              ev_busy,
  output logic              irq
);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_DESC - 1);

  eng_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  cnt, idle_run;
  logic [ERR_W-1:0]  err_q;
  logic              idle_close;
  logic [DATA_W-1:0] byte_q;

  logic [WORD_W-1:0] cur_stat, eng_stat;
  logic [PTR_W-1:0]  cur_ptr;
  logic              eng_len_we, eng_stat_we, set_rx, set_busy;
  logic              accept, cur_empty;
  logic [LEN_W-1:0]  cnt_nx, idle_nx;

  assign ch_ready    = (state == ST_RUN);
  assign accept      = ch_valid && ch_ready;
  assign cur_empty   = cur_stat[S_EMPTY];
  assign cnt_nx      = cnt + LEN_ONE;
  assign idle_nx     = idle_run + LEN_ONE;
  assign mw_valid    = (state == ST_MEM);
  assign mw_addr     = cur_ptr + PTR_W'(cnt);
  assign mw_data     = byte_q;
  assign eng_len_we  = (state == ST_LEN);
  assign eng_stat_we = (state == ST_STAT);
  assign set_busy    = accept && !cur_empty;
  assign set_rx      = eng_stat_we && cur_stat[S_INTR];

  always_comb begin
    eng_stat          = cur_stat & CTL_KEEP;
    eng_stat[S_EMPTY] = cur_stat[S_CONT] && (err_q == '0);
    eng_stat[S_IDLE]  = idle_close;
    eng_stat[S_BRK]   = err_q[3];
    eng_stat[S_FRM]   = err_q[2];
    eng_stat[S_PAR]   = err_q[1];
    eng_stat[S_OVR]   = err_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      idx        <= '0;
      cnt        <= '0;
      idle_run   <= '0;
      err_q      <= '0;
      idle_close <= 1'b0;
      byte_q     <= '0;
    end else begin
      unique case (state)
        ST_RUN: if (accept && cur_empty) begin
          if (ch_err != '0) begin
            err_q      <= ch_err;
            idle_close <= 1'b0;
            state      <= ST_LEN;
          end else if (ch_idle) begin
            if (cnt != '0 && cfg_idle_lim != '0) begin
              if (idle_nx == cfg_idle_lim) begin
                err_q      <= '0;
                idle_close <= 1'b1;
                state      <= ST_LEN;
              end else begin
                idle_run <= idle_nx;
              end
            end
          end else begin
            byte_q   <= ch_data;
            idle_run <= '0;
            state    <= ST_MEM;
          end
        end
        ST_MEM: if (mw_ready) begin
          cnt <= cnt_nx;
          if (cnt_nx == cfg_max_len) begin
            err_q      <= '0;
            idle_close <= 1'b0;
            state      <= ST_LEN;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_LEN: state <= ST_STAT;
        ST_STAT: begin
          idx      <= (cur_stat[S_WRAP] || idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
          cnt      <= '0;
          idle_run <= '0;
          state    <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  rxbd_table #(.N_DESC(N_DESC), .IDX_W(IDX_W), .HA_W(HA_W)) u_table (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .cur_idx(idx), .cur_stat, .cur_ptr,
    .eng_len_we, .eng_len(WORD_W'(cnt)), .eng_stat_we, .eng_stat
  );

  rxbd_events u_events (
    .clk, .rst_n, .set_rx, .set_busy, .clr(ev_clr), .mask(cfg_irq_mask),
    .ev_rx, .ev_busy, .irq
  );

  p_mw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));
  p_byte_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_empty && !ch_idle && ch_err == '0) |=> mw_valid);
  p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cur_empty) |=> (!mw_valid && ev_busy));
  p_len_then_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stat_we |-> $past(eng_len_we));
  p_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid || eng_len_we || eng_stat_we) |-> !ch_ready);
endmodule

// File: tb/test_rxq_bd_engine.sv
`timescale 1ns/1ps
module test_rxq_bd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ch_valid = 0, ch_idle = 0, mw_ready = 0, host_we = 0;
  logic [7:0] ch_data = 0;
  logic [3:0] ch_err = 0;
  logic [15:0] cfg_max_len = 16'd4, cfg_idle_lim = 16'd3, host_wdata = 0;
  logic [1:0] cfg_irq_mask = 2'b11, ev_clr = 0;
  logic [4:0] host_addr = 0;
  logic ch_ready, mw_valid, ev_rx, ev_busy, irq;
  logic [31:0] mw_addr;
  logic [7:0] mw_data;
  logic [15:0] host_rdata;

  rxq_bd_engine i_rxq_bd_engine (
    .clk, .rst_n, .ch_valid, .ch_ready, .ch_data, .ch_idle, .ch_err,
    .cfg_max_len, .cfg_idle_lim, .cfg_irq_mask, .ev_clr,
    .mw_valid, .mw_ready, .mw_addr, .mw_data,
    .host_we, .host_addr, .host_wdata, .host_rdata, .ev_rx, .ev_busy, .irq
  );

  int checks = 0, fails = 0, writes = 0, cyc = 0;
  bit hold_ready = 0, done = 0;
  logic [39:0] exp_q[$];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: memory model and scoreboard
  always @(negedge clk) begin
    cyc++;
    mw_ready = !hold_ready && (cyc % 3 != 0);
    if (rst_n && mw_valid && mw_ready) begin
      writes++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected write %h/%h expected none", mw_addr, mw_data);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        if ({mw_addr, mw_data} !== e) begin
          fails++;
          $display("FAIL R2: write got %h expected %h", {mw_addr, mw_data}, e);
        end
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic idl, input logic [3:0] e);
    ch_data = d; ch_idle = idl; ch_err = e; ch_valid = 1;
    while (!ch_ready) @(negedge clk);
    @(negedge clk);
    ch_valid = 0;
  endtask

  task automatic send_byte(input logic [31:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    send(d, 1'b0, 4'h0);
  endtask

  task automatic hwr(input int idx, input int w, input logic [15:0] v);
    host_addr = 5'(idx * 4 + w); host_wdata = v; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic setup(input int idx, input logic [15:0] st, input logic [31:0] p);
    hwr(idx, 1, 16'h0);
    hwr(idx, 2, p[31:16]);
    hwr(idx, 3, p[15:0]);
    hwr(idx, 0, st);
  endtask

  task automatic hrd(input int idx, input int w, output logic [15:0] v);
    host_addr = 5'(idx * 4 + w);
    #1 v = host_rdata;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
  endtask

  task automatic clear_ev();
    ev_clr = 2'b11;
    @(negedge clk);
    ev_clr = 2'b00;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    int wr0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R11 reset ch_ready", ch_ready, 1);
    chk("R2 reset mw_valid", mw_valid, 0);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset ev_rx", ev_rx, 0);
    hrd(0, 0, v); chk("R1 reset status", v, 16'h0);

    // R1: descriptor owned by host
    wr0 = writes;
    send(8'h55, 0, 0);
    settle();
    chk("R1 no write", writes, wr0);
    chk("R1 busy flag", ev_busy, 1);
    chk("R9 irq from busy", irq, 1);
    clear_ev();
    chk("R9 clear", {ev_rx, ev_busy, irq}, 3'b000);

    // ring: d0 E|I + reserved + stale parity, d1 E|I|CM, d2 E|W
    setup(0, 16'h9808, 32'h0000_1000);
    setup(1, 16'h9200, 32'h0000_2000);
    setup(2, 16'hA000, 32'h0000_3000);

    // R11 back-pressure with memory stalled
    hold_ready = 1;
    exp_q.push_back({32'h1000, 8'hA0});
    send(8'hA0, 0, 0);
    @(negedge clk);
    chk("R11 stall mw_valid", mw_valid, 1);
    chk("R11 ch_ready low", ch_ready, 0);
    chk("R2 stall addr", mw_addr, 32'h1000);
    hold_ready = 0;
    send_byte(32'h1001, 8'hA1);
    send_byte(32'h1002, 8'hA2);
    send_byte(32'h1003, 8'hA3);
    settle();
    hrd(0, 1, v); chk("R3 full length", v, 16'd4);
    hrd(0, 0, v); chk("R10 R3 full status", v, 16'h1000);
    chk("R9 rx event", ev_rx, 1);
    clear_ev();

    // R4: idle run reset by data, R9 mask
    cfg_irq_mask = 2'b10;
    send_byte(32'h2000, 8'hB0);
    send(0, 1, 0); send(0, 1, 0);
    send_byte(32'h2001, 8'hB1);
    send(0, 1, 0); send(0, 1, 0);
    settle();
    hrd(1, 0, v); chk("R4 run reset, still open", v, 16'h9200);
    send(0, 1, 0);
    settle();
    hrd(1, 1, v); chk("R4 idle length", v, 16'd2);
    hrd(1, 0, v); chk("R4 R7 idle status", v, 16'h9300);
    chk("R9 masked ev_rx set", ev_rx, 1);
    chk("R9 masked irq", irq, 0);
    clear_ev();
    cfg_irq_mask = 2'b11;

    // R5: idles on empty buffer, R6 error close
    send(0, 1, 0); send(0, 1, 0); send(0, 1, 0);
    settle();
    hrd(2, 0, v); chk("R5 idles ignored", v, 16'hA000);
    send_byte(32'h3000, 8'hC0);
    send(8'hC1, 0, 4'b0101);
    settle();
    hrd(2, 1, v); chk("R6 error length", v, 16'd1);
    hrd(2, 0, v); chk("R6 error status", v, 16'h2012);
    chk("R9 no I no event", ev_rx, 0);

    // R8: wrap back to entry 0
    setup(0, 16'h9000, 32'h0000_4000);
    send_byte(32'h4000, 8'hD0);
    send_byte(32'h4001, 8'hD1);
    send_byte(32'h4002, 8'hD2);
    send_byte(32'h4003, 8'hD3);
    settle();
    hrd(0, 0, v); chk("R8 wrap entry0 closed", v, 16'h1000);
    clear_ev();

    // R7: revisit CM descriptor overwrites, R6 error clears E under CM
    send_byte(32'h2000, 8'hE0);
    send(8'hE1, 0, 4'b1000);
    settle();
    hrd(1, 1, v); chk("R7 overwrite length", v, 16'd1);
    hrd(1, 0, v); chk("R6 CM error status", v, 16'h1220);

    // R8: next is entry 2 (host-owned) -> dropped
    wr0 = writes;
    send(8'hF0, 0, 0);
    settle();
    chk("R8 R1 step to entry2", writes, wr0);
    chk("R1 busy again", ev_busy, 1);

    done = 1;
    summary();
  end
endmodule